// File: doc/BRIEF.md
# SDRAM Device Write Burst Engine

This block is the write side of a synchronous DRAM device. Each rising clock edge it decodes the chip-select, RAS#, CAS# and WE# pins. When it sees a WRITE it latches the bank, the starting column, the burst-length setting and the auto-precharge flag. The data word on the bus at that same edge is the first beat of the burst. The block then takes one more word on every following edge. For each beat it works out the column and presents one write, with per-byte enables, on a registered port to the storage array.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside their aligned block of columns and stop by themselves. A full-page burst wraps around the whole page and runs until another command arrives. A new WRITE can start on any edge and takes over from the running burst. When the final beat of a burst that was opened with A10 high has been written, the block sends a one-cycle precharge request tagged with the bank number.

Top module: `sdram_wr_burst`

## Requirements
- R1: A WRITE is decoded at a rising edge when cs_n=0, ras_n=1, cas_n=0 and we_n=0. The din word at that same edge is beat 0. It is written to bank ba at column addr[9:0], and arr_we is high with that beat during the following clock cycle.
- R2: Every later edge of an active burst captures the next din word. Each such beat is written on the array port in the cycle after its edge, one beat per cycle.
- R3: burst_cfg is sampled with the WRITE. Codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats, and any code with bit 2 set selects a full page. After the last beat of a fixed burst, arr_we stays low and din is ignored.
- R4: For a fixed burst of length BL starting at column S, beat k goes to column (S with its low log2(BL) bits replaced by (S+k) mod BL).
- R5: In a full-page burst, beat k goes to column (S+k) mod 1024. The burst goes on with no limit on its length.
- R6: arr_be[i] is the inverse of dmask[i] sampled with that beat, so a mask bit only affects its own beat. arr_be is 0 whenever arr_we is low.
- R7: A burst opened with addr[10]=1 that completes its final beat raises ap_valid for one cycle, with ap_bank set to its bank. The pulse comes in the cycle right after the array write of that final beat. A burst opened with addr[10]=0 never raises ap_valid.
- R8: A WRITE on any edge while a burst is active ends the old burst at once. The data at that edge belongs to the new burst, and the truncated burst raises no precharge request.
- R9: Any other command with cs_n=0 (anything except a WRITE and except NOP, where ras_n, cas_n and we_n are all 1) ends an active burst. The data at that edge is not written and no precharge request is raised. While cs_n=1 the pins are ignored and an active burst carries on.
- R10: The active-low synchronous reset leaves the block idle, with arr_we, arr_be and ap_valid low.
- R11: Back-to-back WRITEs may target different banks, and each beat is written to the bank of the burst it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write-enable command pin |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus; [9:0] starting column, [10] auto-precharge enable |
| burst_cfg | input | 3 | Burst length setting, sampled with WRITE |
| din | input | 16 | Write data |
| dmask | input | 2 | Per-byte write mask, high blocks that byte |
| arr_we | output | 1 | Array write strobe |
| arr_bank | output | 2 | Array write bank |
| arr_col | output | 10 | Array write column |
| arr_data | output | 16 | Array write data |
| arr_be | output | 2 | Array byte enables |
| ap_valid | output | 1 | One-cycle auto-precharge request |
| ap_bank | output | 2 | Bank to precharge |

## Verification
The bench targets a few specific corner cases. An 8-beat burst that starts mid-block must fold back to the block base; a design that simply counts upward would write outside the aligned group. A full-page burst that starts two columns before the end of the page must roll over to column 0 and keep going; a design that treats full page as a long fixed burst would stop or spill into the next page. A WRITE that lands exactly on the final-beat edge of an auto-precharge burst must take that data and must cancel the pending precharge; a design that gets this wrong writes the word to the old column or sends a false precharge. Other commands, chip-deselected cycles, masked bytes and 1-beat bursts issued back to back to different banks are also exercised, mixed in with random traffic. The expected values come from a bench model written from the requirements.

// File: rtl/sdram_wr_pkg.sv
// Shared types for the SDRAM write burst engine.
// Assumes the command pins are decoded only on the rising clock edge.
package sdram_wr_pkg;

    // Command classes the write path cares about.
    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_OTHER = 2'd2
    } cmd_e;

    // Width of the burst-length code: [1:0] log2 of length, [2] full page.
    localparam int CFG_W = 3;

endpackage

// File: rtl/wr_cmd_decode.sv
// Command decoder: classifies the pin state on each edge as a WRITE,
// a NOP (or deselected cycle), or some other command.
// Assumes the pins are stable around the rising edge; purely combinational.
module wr_cmd_decode
    import sdram_wr_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Map the pin pattern to a command class.
    always_comb begin
        if (cs_n)
            cmd = CMD_NOP;
        else if (ras_n && !cas_n && !we_n)
            cmd = CMD_WRITE;
        else if (ras_n && cas_n && we_n)
            cmd = CMD_NOP;
        else
            cmd = CMD_OTHER;
    end

endmodule

// File: rtl/wr_col_gen.sv
// Column generator: gives the column of beat idx of a burst that starts at
// start. Fixed bursts wrap inside their aligned block, full page wraps the page.
// Assumes the burst length is a power of two no larger than the page.
module wr_col_gen #(
    parameter int COL_W = 10,
    parameter int LOG_W = 2
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] idx,
    input  logic [LOG_W-1:0] len_log,
    input  logic             full,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] sum;

    // Merge the fixed high bits of the start with the advancing low bits.
    always_comb begin
        wrap_mask = full ? {COL_W{1'b1}} : ((COL_W'(1) << len_log) - COL_W'(1));
        sum       = start + idx;
        col       = (start & ~wrap_mask) | (sum & wrap_mask);
    end

endmodule

// File: rtl/wr_burst_ctrl.sv
// Burst controller: holds the state of the running burst. Each edge it says
// whether a beat is taken and which beat it is, whether it is the last one,
// and which bank and precharge flag go with it.
// Assumes cmd comes from wr_cmd_decode. A WRITE always starts a fresh burst.
module wr_burst_ctrl
    import sdram_wr_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int BANK_W = 2,
    localparam int LOG_W = CFG_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_ap,
    input  logic [CFG_W-1:0]  cfg,
    output logic              beat_v,
    output logic              beat_last,
    output logic              beat_ap,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_start,
    output logic [COL_W-1:0]  beat_idx,
    output logic [LOG_W-1:0]  beat_log,
    output logic              beat_full
);

    logic              active_q;
    logic              full_q;
    logic [LOG_W-1:0]  log_q;
    logic [COL_W-1:0]  start_q;
    logic [COL_W-1:0]  cnt_q;
    logic [BANK_W-1:0] bank_q;
    logic              ap_q;
    logic              is_wr;
    logic              is_oth;
    logic [COL_W-1:0]  len_m1;

    // Pick the settings from the new command or from the running burst.
    always_comb begin
        is_wr      = (cmd == CMD_WRITE);
        is_oth     = (cmd == CMD_OTHER);
        beat_v     = is_wr || (active_q && !is_oth);
        beat_full  = is_wr ? cfg[CFG_W-1]       : full_q;
        beat_log   = is_wr ? cfg[LOG_W-1:0]     : log_q;
        beat_start = is_wr ? cmd_col            : start_q;
        beat_idx   = is_wr ? '0                 : cnt_q;
        beat_bank  = is_wr ? cmd_bank           : bank_q;
        beat_ap    = is_wr ? cmd_ap             : ap_q;
        len_m1     = (COL_W'(1) << beat_log) - COL_W'(1);
        beat_last  = beat_v && !beat_full && (beat_idx == len_m1);
    end

    // Advance, restart or end the burst on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            full_q   <= 1'b0;
            log_q    <= '0;
            start_q  <= '0;
            cnt_q    <= '0;
            bank_q   <= '0;
            ap_q     <= 1'b0;
        end else if (is_wr) begin
            active_q <= !beat_last;
            full_q   <= beat_full;
            log_q    <= beat_log;
            start_q  <= cmd_col;
            cnt_q    <= COL_W'(1);
            bank_q   <= cmd_bank;
            ap_q     <= cmd_ap;
        end else if (is_oth) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            cnt_q <= cnt_q + COL_W'(1);
            if (beat_last)
                active_q <= 1'b0;
        end
    end

    // R3
    fixed_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !full_q) |-> (cnt_q < (COL_W'(1) << log_q)));

    // R5
    full_page_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && full_q && cmd == CMD_NOP) |=> active_q);

endmodule

// File: rtl/sdram_wr_burst.sv
// SDRAM write burst engine, top level. Decodes WRITE commands and writes
// each burst beat to the array port one cycle after its clock edge. Sends a
// one-cycle precharge request after the final beat of an auto-precharge burst.
// Assumes the array accepts one write per cycle with no back-pressure.
module sdram_wr_burst
    import sdram_wr_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10,
    parameter int DATA_W = 16,
    localparam int BYTES = DATA_W / 8,
    localparam int LOG_W = CFG_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  burst_cfg,
    input  logic [DATA_W-1:0] din,
    input  logic [BYTES-1:0]  dmask,
    output logic              arr_we,
    output logic [BANK_W-1:0] arr_bank,
    output logic [COL_W-1:0]  arr_col,
    output logic [DATA_W-1:0] arr_data,
    output logic [BYTES-1:0]  arr_be,
    output logic              ap_valid,
    output logic [BANK_W-1:0] ap_bank
);

    cmd_e              cmd;
    logic              beat_v;
    logic              beat_last;
    logic              beat_ap;
    logic [BANK_W-1:0] beat_bank;
    logic [COL_W-1:0]  beat_start;
    logic [COL_W-1:0]  beat_idx;
    logic [LOG_W-1:0]  beat_log;
    logic              beat_full;
    logic [COL_W-1:0]  beat_col;
    logic              fin_q;
    logic [BANK_W-1:0] fin_bank_q;

    wr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    wr_burst_ctrl #(
        .COL_W  (COL_W),
        .BANK_W (BANK_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .cmd_bank   (ba),
        .cmd_col    (addr[COL_W-1:0]),
        .cmd_ap     (addr[AP_BIT]),
        .cfg        (burst_cfg),
        .beat_v     (beat_v),
        .beat_last  (beat_last),
        .beat_ap    (beat_ap),
        .beat_bank  (beat_bank),
        .beat_start (beat_start),
        .beat_idx   (beat_idx),
        .beat_log   (beat_log),
        .beat_full  (beat_full)
    );

    wr_col_gen #(
        .COL_W (COL_W),
        .LOG_W (LOG_W)
    ) u_col (
        .start   (beat_start),
        .idx     (beat_idx),
        .len_log (beat_log),
        .full    (beat_full),
        .col     (beat_col)
    );

    // Register one beat per edge onto the array write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_we   <= 1'b0;
            arr_bank <= '0;
            arr_col  <= '0;
            arr_data <= '0;
            arr_be   <= '0;
        end else begin
            arr_we   <= beat_v;
            arr_bank <= beat_bank;
            arr_col  <= beat_col;
            arr_data <= din;
            arr_be   <= beat_v ? ~dmask : '0;
        end
    end

    // Delay the completion flag so the request follows the final array write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q      <= 1'b0;
            fin_bank_q <= '0;
            ap_valid   <= 1'b0;
            ap_bank    <= '0;
        end else begin
            fin_q      <= beat_last && beat_ap;
            fin_bank_q <= beat_bank;
            ap_valid   <= fin_q;
            ap_bank    <= fin_bank_q;
        end
    end

    // R1
    beat_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE) |=> arr_we);

    // R7
    ap_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_valid |-> $past(arr_we));

    // R6
    be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_we |-> (arr_be == '0));

endmodule

// File: tb/sdram_wr_burst_tb.sv
// Bench for sdram_wr_burst: directed corner cases plus seeded random
// traffic, compared each cycle against a model written from the requirements.
module sdram_wr_burst_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [2:0]  burst_cfg = '0;
    logic [15:0] din = '0;
    logic [1:0]  dmask = '0;
    logic        arr_we, ap_valid;
    logic [1:0]  arr_bank, arr_be, ap_bank;
    logic [9:0]  arr_col;
    logic [15:0] arr_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string ph = "";

    // model state
    bit m_act = 0, m_full = 0, m_ap = 0;
    int m_len = 1, m_start = 0, m_cnt = 0, m_bank = 0;
    // expected outputs
    bit e_we = 0, e_full = 0, fin1 = 0, fin2 = 0;
    int e_col = 0, e_bank = 0, e_data = 0, e_be = 0, fb1 = 0, fb2 = 0;
    bit checking = 0;

    always #10 clk = ~clk;

    sdram_wr_burst u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .burst_cfg(burst_cfg), .din(din),
        .dmask(dmask), .arr_we(arr_we), .arr_bank(arr_bank), .arr_col(arr_col),
        .arr_data(arr_data), .arr_be(arr_be), .ap_valid(ap_valid), .ap_bank(ap_bank)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s [%s] actual=%0h expected=%0h t=%0t", req, ph, act, exp, $time);
        end
    endtask

    function automatic int fixed_col(input int s, input int k, input int len);
        return (s / len) * len + ((s + k) % len);
    endfunction

    function automatic int page_col(input int s, input int k);
        return (s + k) % 1024;
    endfunction

    task automatic check_outputs();
        chk("R2", int'(arr_we), int'(e_we));
        if (e_we) begin
            chk("R1", int'(arr_data), e_data);
            chk(e_full ? "R5" : "R4", int'(arr_col), e_col);
            chk("R6", int'(arr_be), e_be);
            chk("R11", int'(arr_bank), e_bank);
        end else begin
            chk("R6", int'(arr_be), 0);
        end
        chk("R7", int'(ap_valid), int'(fin2));
        if (fin2) chk("R7", int'(ap_bank), fb2);
    endtask

    // One cycle: check the previous results, drive the new pins, update the model.
    task automatic step(input bit c, input bit r, input bit ca, input bit w,
                        input int b, input int a, input int cfg, input int d, input int m);
        bit wr, oth, beat, last;
        @(negedge clk);
        if (checking) check_outputs();
        cs_n = c; ras_n = r; cas_n = ca; we_n = w;
        ba = 2'(b); addr = 13'(a); burst_cfg = 3'(cfg); din = 16'(d); dmask = 2'(m);
        wr  = !c && r && !ca && !w;
        oth = !c && !wr && !(r && ca && w);
        fin2 = fin1; fb2 = fb1;
        if (wr) begin
            m_act = 1; m_full = cfg[2]; m_len = 1 << (cfg & 3);
            m_start = a & 1023; m_cnt = 0; m_bank = b; m_ap = a[10];
            beat = 1;
        end else if (oth) begin
            m_act = 0; beat = 0;
        end else begin
            beat = m_act;
        end
        e_we = beat; fin1 = 0;
        if (beat) begin
            e_full = m_full;
            e_col = m_full ? page_col(m_start, m_cnt) : fixed_col(m_start, m_cnt, m_len);
            e_data = d & 16'hffff; e_be = (~m) & 3; e_bank = m_bank;
            last = !m_full && (m_cnt == m_len - 1);
            fin1 = last && m_ap; fb1 = m_bank;
            m_cnt++;
            if (last) m_act = 0;
        end
    endtask

    task automatic nop(input int d);
        step(0, 1, 1, 1, 0, 0, 0, d, 0);
    endtask

    task automatic wr(input int b, input int col, input bit ap, input int cfg, input int d, input int m);
        step(0, 1, 0, 0, b, (int'(ap) << 10) | col, cfg, d, m);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; checking = 0;
        repeat (3) @(negedge clk);
        m_act = 0; e_we = 0; fin1 = 0; fin2 = 0;
        rst_n = 1; checking = 1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R10: outputs idle right after reset
        ph = "R10 reset";
        @(negedge clk);
        chk("R10", int'(arr_we), 0);
        chk("R10", int'(ap_valid), 0);
        chk("R10", int'(arr_be), 0);

        ph = "R4 BL8 mid-block";
        wr(2, 13, 1, 3, 16'h1000, 0);
        for (int i = 1; i < 8; i++) nop(16'h1000 + i);
        ph = "R3 after fixed end";
        for (int i = 0; i < 4; i++) nop(16'hdead);

        ph = "R5 full page wrap";
        wr(1, 1022, 1, 4, 16'h2000, 1);
        for (int i = 1; i < 6; i++) nop(16'h2000 + i);
        ph = "R9 deselect keeps burst";
        step(1, 0, 1, 0, 3, 0, 0, 16'h2100, 2);
        step(1, 1, 0, 0, 3, 5, 0, 16'h2101, 0);
        ph = "R9 other cmd ends";
        step(0, 0, 1, 0, 1, 0, 0, 16'h2200, 0);
        for (int i = 0; i < 3; i++) nop(16'hbeef);

        ph = "R8 truncate on last edge";
        wr(1, 40, 1, 2, 16'h3000, 0);
        nop(16'h3001);
        nop(16'h3002);
        wr(3, 7, 1, 0, 16'h3100, 2);
        for (int i = 0; i < 4; i++) nop(16'h3200);

        ph = "R9 other cmd on last beat";
        wr(0, 100, 1, 1, 16'h3300, 0);
        step(0, 0, 1, 0, 0, 0, 0, 16'h3301, 0);
        for (int i = 0; i < 3; i++) nop(16'h3302);

        ph = "R11 BL1 back to back";
        wr(0, 5, 1, 0, 16'h4000, 0);
        wr(1, 6, 1, 0, 16'h4001, 1);
        wr(2, 7, 0, 0, 16'h4002, 3);
        wr(3, 8, 1, 0, 16'h4003, 0);
        for (int i = 0; i < 3; i++) nop(0);

        ph = "R1 random";
        for (int i = 0; i < 4000; i++) begin
            int sel = int'($urandom_range(0, 99));
            int d = int'($urandom_range(0, 65535));
            int m = int'($urandom_range(0, 3));
            int b = int'($urandom_range(0, 3));
            int a = int'($urandom_range(0, 8191));
            int cfg = int'($urandom_range(0, 7));
            if (sel < 14) wr(b, a & 1023, a[10], cfg, d, m);
            else if (sel < 17) step(0, $urandom_range(0, 1) == 1, 1, 0, b, a, cfg, d, m);
            else if (sel < 27) step(1, $urandom_range(0, 1) == 1, 0, 0, b, a, cfg, d, m);
            else nop(d);
        end
        for (int i = 0; i < 3; i++) nop(0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog [%s] actual=hung expected=finished", ph);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule